// File: doc/BRIEF.md
# Page Hamming ECC accumulator

The block sits on the byte stream between a host and a NAND flash device and computes single-error-correcting Hamming parity over each fixed-size chunk of data (256 bytes by default). Every accepted byte adds to a line parity, which is indexed by the byte's position in the chunk, and to a column parity, which is indexed by bit position inside the byte. When the last byte of a chunk is accepted, the combined parity is latched into a packed 32-bit ECC word, a one-cycle valid strobe is raised, and the accumulator starts again from zero for the next chunk.

A formatter turns the ECC word into the 24-bit code that is written to the spare area. The same code is computed again when the chunk is read back. The XOR of the stored and recomputed codes then gives the byte address and bit position of a single flipped bit. Syndrome decoding and correction are done elsewhere.

Top module: `ecc_page_acc`

## Requirements
- R1: After reset, ecc_o is 0, ecc_vld_o is 0 and code_o is 24'hFFFFFF.
- R2: Line parity sits in ecc_o[20:6]. For byte address bit k (0..6), field bit 2k is the XOR of the parity of all bytes whose address bit k is 0, and field bit 2k+1 is the same for address bit k equal to 1. Field bit 14 is the XOR of the parity of the bytes whose address bit 7 is 1.
- R3: Column parity sits in ecc_o[5:0]. For bit-index bit j (0..2), bit 2j is the XOR over the chunk of all data bits whose index has bit j clear, and bit 2j+1 is the same for index bit j set.
- R4: ecc_o[31:21] is always 0.
- R5: One cycle after the 256th accepted byte of a chunk, ecc_o shows that chunk's parity and ecc_vld_o is high for exactly that one cycle. At all other times ecc_o holds its value unless a clear occurs.
- R6: After a chunk completes, the accumulator and the byte address restart from zero, so each chunk's result depends only on its own bytes.
- R7: A byte presented while ecc_en_i is 0 is ignored: it does not change the parity or advance the byte address.
- R8: ecc_clr_i zeroes the accumulator, the byte address and ecc_o in the next cycle, and takes priority over a byte presented in the same cycle.
- R9: code_o equals the bitwise inverse of ecc_o shifted left by 2, limited to 24 bits. The byte code_o[23:16] is stored first, then [15:8], then [7:0].
- R10: Cycles with byte_vld_i at 0 are ignored, so gaps in the stream do not change the result.
- R11: If one data bit of a chunk is flipped, the XOR of the two codes shifted right by 2 has the flipped byte's address in its line odd bits (field bits 1,3,..,13 and 14) and the bit index in column bits 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | Accumulation enable |
| ecc_clr_i | input | 1 | Synchronous clear of accumulator and ECC word |
| byte_vld_i | input | 1 | Byte on byte_i is valid this cycle |
| byte_i | input | 8 | Data byte |
| ecc_o | output | 32 | Latched ECC word: line parity [20:6], column parity [5:0] |
| ecc_vld_o | output | 1 | One-cycle strobe when ecc_o is updated at chunk end |
| code_o | output | 24 | Storage code derived from ecc_o |

## Verification
The ECC word and its strobe are due on the clock edge after the one that accepts the last byte of a chunk. The storage code follows ecc_o combinationally in that same cycle. A clear is visible on ecc_o one edge after it is sampled. The bench drives inputs on falling edges and samples on the following falling edge, which is the first point at which a result registered on the rising edge can be observed. It checks the strobe at that point and checks that the strobe is low again one cycle later.

// File: rtl/ecc_page_pkg.sv
package ecc_page_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned CHUNK_BYTES = 256;
  localparam int unsigned ECC_W       = 32;
  localparam int unsigned CODE_W      = 24;
  localparam int unsigned ADDR_W      = $clog2(CHUNK_BYTES);
  localparam int unsigned BIT_W       = $clog2(DATA_W);
  localparam int unsigned LINE_W      = 2 * ADDR_W - 1;
  localparam int unsigned COL_W       = 2 * BIT_W;
  typedef logic [ECC_W-1:0] ecc_word_t;
endpackage

// File: rtl/ecc_line_acc.sv
module ecc_line_acc #(
  parameter int unsigned CHUNK_BYTES = ecc_page_pkg::CHUNK_BYTES,
  parameter int unsigned DATA_W      = ecc_page_pkg::DATA_W,
  localparam int unsigned ADDR_W     = $clog2(CHUNK_BYTES),
  localparam int unsigned LINE_W     = 2 * ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              last_o,
  output logic [LINE_W-1:0] line_next_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CHUNK_BYTES - 1);

  logic [ADDR_W-1:0] cnt_q;
  logic [LINE_W-1:0] line_q, contrib;
  logic              bpar;

  assign bpar = ^byte_i;

  generate
    for (genvar k = 0; k < ADDR_W - 1; k++) begin : g_pair
      assign contrib[2*k]   = bpar & ~cnt_q[k];
      assign contrib[2*k+1] = bpar &  cnt_q[k];
    end
  endgenerate
  // top address bit keeps only its odd half
  assign contrib[LINE_W-1] = bpar & cnt_q[ADDR_W-1];

  assign line_next_o = line_q ^ contrib;
  assign last_o      = take_i && (cnt_q == LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      line_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      line_q <= '0;
    end else if (take_i) begin
      cnt_q  <= cnt_q + 1'b1;
      line_q <= last_o ? '0 : line_next_o;
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> $stable(cnt_q)); // R7
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && line_q == '0)); // R8
  AST_CHUNK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !clr_i) |=> (cnt_q == '0 && line_q == '0)); // R6
endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc #(
  parameter int unsigned DATA_W = ecc_page_pkg::DATA_W,
  localparam int unsigned BIT_W = $clog2(DATA_W),
  localparam int unsigned COL_W = 2 * BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [COL_W-1:0]  col_next_o
);
  logic [COL_W-1:0] col_q, contrib;

  generate
    for (genvar j = 0; j < BIT_W; j++) begin : g_sel
      logic [DATA_W-1:0] hi_mask;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign hi_mask[i] = ((i >> j) & 1) == 1;
      end
      assign contrib[2*j]   = ^(byte_i & ~hi_mask);
      assign contrib[2*j+1] = ^(byte_i &  hi_mask);
    end
  endgenerate

  assign col_next_o = col_q ^ contrib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_q <= '0;
    else if (clr_i)  col_q <= '0;
    else if (take_i) col_q <= last_i ? '0 : col_next_o;
  end

  AST_COL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> $stable(col_q)); // R10
endmodule

// File: rtl/ecc_code_fmt.sv
module ecc_code_fmt #(
  parameter int unsigned ECC_W  = ecc_page_pkg::ECC_W,
  parameter int unsigned CODE_W = ecc_page_pkg::CODE_W
) (
  input  logic [ECC_W-1:0]  ecc_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] shifted;
  assign shifted = {ecc_i[CODE_W-3:0], 2'b00};
  assign code_o  = ~shifted;
endmodule

// File: rtl/ecc_page_acc.sv
module ecc_page_acc
  import ecc_page_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              ecc_clr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [ECC_W-1:0]  ecc_o,
  output logic              ecc_vld_o,
  output logic [CODE_W-1:0] code_o
);
  logic              take, last;
  logic [LINE_W-1:0] line_next;
  logic [COL_W-1:0]  col_next;
  ecc_word_t         packed_w, ecc_q;
  logic              vld_q;

  assign take = byte_vld_i & ecc_en_i & ~ecc_clr_i;

  ecc_line_acc #(.CHUNK_BYTES(CHUNK_BYTES), .DATA_W(DATA_W)) u_line (
    .clk_i, .rst_ni, .take_i(take), .clr_i(ecc_clr_i), .byte_i,
    .last_o(last), .line_next_o(line_next)
  );

  ecc_col_acc #(.DATA_W(DATA_W)) u_col (
    .clk_i, .rst_ni, .take_i(take), .last_i(last), .clr_i(ecc_clr_i), .byte_i,
    .col_next_o(col_next)
  );

  always_comb begin
    packed_w = '0;
    packed_w[COL_W +: LINE_W] = line_next;
    packed_w[COL_W-1:0]       = col_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= last;
      if (ecc_clr_i) ecc_q <= '0;
      else if (last) ecc_q <= packed_w;
    end
  end

  assign ecc_o     = ecc_q;
  assign ecc_vld_o = vld_q;

  ecc_code_fmt #(.ECC_W(ECC_W), .CODE_W(CODE_W)) u_fmt (
    .ecc_i(ecc_q), .code_o
  );

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_vld_o |=> !ecc_vld_o); // R5
  AST_ECC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last && !ecc_clr_i) |=> $stable(ecc_o)); // R5
  AST_CLR_ECC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_clr_i |=> (ecc_o == '0 && !ecc_vld_o)); // R8
  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_o[ECC_W-1:COL_W+LINE_W] == '0); // R4
endmodule

// File: tb/ecc_page_acc_test.sv
module ecc_page_acc_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 5;
  // {addr, value, expected ecc}
  localparam logic [47:0] VECS [NVEC] = '{
    {8'h00, 8'h01, 32'h0005_5555},
    {8'hFF, 8'h80, 32'h001A_AAAA},
    {8'h00, 8'h03, 32'h0000_0003},
    {8'h81, 8'hFF, 32'h0000_0000},
    {8'h05, 8'h10, 32'h0005_59A5}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ecc_en_i = 1'b0, ecc_clr_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [31:0] ecc_o;
  logic        ecc_vld_o;
  logic [23:0] code_o;

  int checks = 0, failures = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_page_acc uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_code(input logic [31:0] e);
    logic [31:0] s = ~(e << 2);
    return s[23:0];
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] r = '0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (mem[a][b]) begin
          for (int k = 0; k < 7; k++) r[6 + 2*k + ((a >> k) & 1)] ^= 1'b1;
          if (a >= 128) r[20] ^= 1'b1;
          for (int j = 0; j < 3; j++) r[2*j + ((b >> j) & 1)] ^= 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic put(input logic [7:0] v, input logic vld, input logic en);
    @(negedge clk_i);
    byte_vld_i = vld; ecc_en_i = en; byte_i = v;
  endtask

  task automatic send_mem(input bit gaps);
    for (int a = 0; a < 256; a++) begin
      if (gaps && (a % 5 == 0)) put(8'hA5, 1'b0, 1'b1); // R10 idle cycle
      put(mem[a], 1'b1, 1'b1);
    end
    put(8'h00, 1'b0, 1'b1);
  endtask

  task automatic fill_single(input logic [7:0] a, input logic [7:0] v);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[a] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] e1, e2, d;
    logic [23:0] c1, c2;
    logic [7:0]  loc_a;
    logic [2:0]  loc_b;
    repeat (3) @(negedge clk_i);
    chk("R1 ecc", ecc_o, 32'h0);
    chk("R1 vld", {31'h0, ecc_vld_o}, 32'h0);
    chk("R1 code", {8'h0, code_o}, 32'h00FF_FFFF);
    rst_ni = 1'b1;

    foreach (VECS[n]) begin
      fill_single(VECS[n][47:40], VECS[n][39:32]);
      send_mem(1'b0);
      chk("R2 R3 ecc", ecc_o, VECS[n][31:0]);
      chk("R5 vld", {31'h0, ecc_vld_o}, 32'h1);
      chk("R9 code", {8'h0, code_o}, {8'h0, mk_code(VECS[n][31:0])});
      chk("R4 hi", {21'h0, ecc_o[31:21]}, 32'h0);
      @(negedge clk_i);
      chk("R5 vld drop", {31'h0, ecc_vld_o}, 32'h0);
      chk("R5 hold", ecc_o, VECS[n][31:0]);
    end

    // R6 R2 R3: patterned chunk, then a second chunk back to back
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    send_mem(1'b0);
    e1 = model(); c1 = code_o;
    chk("R2 R3 pattern", ecc_o, e1);
    fill_single(8'h05, 8'h10);
    send_mem(1'b0);
    chk("R6 restart", ecc_o, 32'h0005_59A5);

    // R7: disabled bytes ignored
    for (int i = 0; i < 10; i++) put(8'hFF, 1'b1, 1'b0);
    fill_single(8'h00, 8'h01);
    send_mem(1'b0);
    chk("R7 disabled ignored", ecc_o, 32'h0005_5555);

    // R10: gaps in the stream
    fill_single(8'hFF, 8'h80);
    send_mem(1'b1);
    chk("R10 gaps", ecc_o, 32'h001A_AAAA);

    // R8: clear mid-chunk and on output
    for (int i = 0; i < 100; i++) put(8'h37, 1'b1, 1'b1);
    @(negedge clk_i);
    byte_vld_i = 1'b1; byte_i = 8'hFF; ecc_clr_i = 1'b1;
    @(negedge clk_i);
    ecc_clr_i = 1'b0; byte_vld_i = 1'b0;
    chk("R8 ecc zero", ecc_o, 32'h0);
    chk("R8 code", {8'h0, code_o}, 32'h00FF_FFFF);
    fill_single(8'h05, 8'h10);
    send_mem(1'b0);
    chk("R8 restart", ecc_o, 32'h0005_59A5);

    // R11: single flipped bit located from codes
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'hA7][5] = ~mem[8'hA7][5];
    send_mem(1'b0);
    e2 = ecc_o; c2 = code_o;
    chk("R11 model", e2, model());
    d = {8'h0, c1 ^ c2} >> 2;
    for (int k = 0; k < 7; k++) loc_a[k] = d[6 + 2*k + 1];
    loc_a[7] = d[20];
    for (int j = 0; j < 3; j++) loc_b[j] = d[2*j + 1];
    chk("R11 addr", {24'h0, loc_a}, 32'h0000_00A7);
    chk("R11 bit", {29'h0, loc_b}, 32'h0000_0005);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule